// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block runs one block-erase operation against a parallel NOR-style flash array made of one or more chips side by side (lanes) that share one data bus and are always addressed together. A requester hands it a byte address that already sits on an erase-block boundary. The sequencer converts that address to a bus word address and raises the programming-voltage enable. It writes the erase setup and confirm commands to the block, then keeps reading the block's status word until every lane reports ready or a millisecond-scale timeout runs out.

Clean-up always follows, whether polling ended with ready or with a timeout. The voltage enable drops, the status registers are cleared and the array is put back into read mode. The sequencer then reports a per-lane error code and the last status word it read, and pulses `done`. Every flash access uses a simple request/acknowledge handshake, so devices with any access latency can be used.

Top module: `fers_erase_seq`

## Requirements
- R1: After reset `busy`, `done`, `vpp_en` and `fl_req` are low and `err_code` and `last_status` are zero.
- R2: Every flash access of an operation uses the word address `req_addr >> SHIFT`, where SHIFT is log2 of the bus width in bytes (1 with the defaults: two 8-bit lanes).
- R3: `vpp_en` is high from the cycle after the request is accepted through the end of polling. It is high during the setup write, the confirm write and every status read. It is low during the clear-status and read-mode writes.
- R4: The write sequence of one operation is exactly 0x20, 0xD0, then after polling 0x50, 0xFF. Each command byte is placed zero-extended in every lane, with lane i at bits [i*LANE_W +: LANE_W].
- R5: Lane i reports ready when bit 7 of its status byte is set. Polling continues until all lanes report ready, so the number of status reads equals the read on which the slowest lane first shows ready.
- R6: If `CLK_KHZ*TIMEOUT_MS` cycles of polling pass without all lanes ready, the next completed read ends polling. Any lane still not ready gets code 4 (timeout), and clean-up still runs.
- R7: The code for a ready lane, at bits [3i+2:3i] of `err_code`, is 1 if status bit 1 (locked) is set. Otherwise it is 2 if bit 3 (low programming voltage) is set. Otherwise it is 3 if bit 4 or bit 5 (program/erase failure) is set. Otherwise it is 0. Codes hold until the next request is accepted.
- R8: `last_status` holds the status word from the final read of the operation.
- R9: `req_valid` is ignored while `busy` is high. It is sampled in the idle state, including the cycle in which `done` is high.
- R10: `done` is high for exactly one cycle, in the same cycle in which `busy` falls, and `err_code` is valid in that cycle.
- R11: Once raised, `fl_req` with its address, direction and write data stays unchanged until the cycle `fl_ack` is high. It is then low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start an erase (sampled when idle) |
| req_addr | input | ADDR_W | Block-aligned byte address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3*LANES | Per-lane result code |
| last_status | output | LANES*LANE_W | Final status word read |
| vpp_en | output | 1 | Programming-voltage enable |
| fl_req | output | 1 | Flash access request |
| fl_we | output | 1 | Access is a write |
| fl_addr | output | ADDR_W-SHIFT | Flash word address |
| fl_wdata | output | LANES*LANE_W | Flash write data |
| fl_ack | input | 1 | Access complete (read data valid) |
| fl_rdata | input | LANES*LANE_W | Flash read data |

## Verification
Two things can happen in the same cycle: a completion and the acceptance of a new request. `done` goes high in the idle state, so a `req_valid` held high across that cycle starts the next erase at once. A request shown one cycle earlier, while `busy` is still high, must have no effect. The bench holds `req_valid` high with a second address for the whole first operation. It then checks that `busy` rises right after `done` and that the first operation's accesses used only the first address. It also checks that the second operation used only the second address and issued exactly four writes. A separate case lands a stray request in the middle of an operation and checks that no extra operation and no address change follow.

// File: rtl/fers_pkg.sv
package fers_pkg;

  // Result codes reported per lane
  typedef enum logic [2:0] {
    ERC_NONE    = 3'd0,
    ERC_LOCKED  = 3'd1,
    ERC_LOWVPP  = 3'd2,
    ERC_FAILED  = 3'd3,
    ERC_TIMEOUT = 3'd4
  } fers_err_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PWR,
    SQ_SETUP,
    SQ_CONF,
    SQ_POLL,
    SQ_CLR,
    SQ_RST
  } fers_state_e;

  // Command bytes
  localparam logic [7:0] CMD_SETUP   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLRST   = 8'h50;
  localparam logic [7:0] CMD_READARR = 8'hFF;

  // Status bit positions
  localparam int ST_READY = 7;
  localparam int ST_LOCK  = 1;
  localparam int ST_VPP   = 3;
  localparam int ST_PROG  = 4;
  localparam int ST_ERASE = 5;

  function automatic fers_err_e fers_classify(input logic [7:0] st);
    if (!st[ST_READY])                  return ERC_TIMEOUT;
    else if (st[ST_LOCK])               return ERC_LOCKED;
    else if (st[ST_VPP])                return ERC_LOWVPP;
    else if (st[ST_PROG] || st[ST_ERASE]) return ERC_FAILED;
    else                                return ERC_NONE;
  endfunction

endpackage

// File: rtl/fers_lane_decode.sv
module fers_lane_decode
  import fers_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] status,
  output logic              ready,
  output fers_err_e         code
);

  always_comb begin
    ready = status[ST_READY];
    code  = fers_classify(status[7:0]);
  end

  always_comb begin
    a_r7_code_range: assert (code <= ERC_TIMEOUT);
  end

endmodule

// File: rtl/fers_poll_timer.sv
module fers_poll_timer #(
  parameter int LIMIT = 1000,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (run && cnt != CW'(LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt == CW'(LIMIT));

  a_r6_timer_holds: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr) |=> expired);

endmodule

// File: rtl/fers_bus_if.sv
module fers_bus_if #(
  parameter int AW = 23,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          xfer_done,
  output logic [DW-1:0] rdata,
  output logic          fl_req,
  output logic          fl_we,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic          fl_ack,
  input  logic [DW-1:0] fl_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fl_req    <= 1'b0;
      fl_we     <= 1'b0;
      fl_addr   <= '0;
      fl_wdata  <= '0;
      xfer_done <= 1'b0;
      rdata     <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (fl_req) begin
        if (fl_ack) begin
          fl_req    <= 1'b0;
          xfer_done <= 1'b1;
          if (!fl_we) rdata <= fl_rdata;
        end
      end else if (start) begin
        fl_req   <= 1'b1;
        fl_we    <= we;
        fl_addr  <= addr;
        fl_wdata <= wdata;
      end
    end
  end

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr) && $stable(fl_we) && $stable(fl_wdata)));

  a_r11_gap: assert property (@(posedge clk) disable iff (rst)
    (fl_req && fl_ack) |=> !fl_req);

endmodule

// File: rtl/fers_erase_seq.sv
module fers_erase_seq
  import fers_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LANES      = 2,
  parameter int LANE_W     = 8,
  parameter int CLK_KHZ    = 50000,
  parameter int TIMEOUT_MS = 1500,
  localparam int WORD_W    = LANES * LANE_W,
  localparam int SHIFT     = $clog2(WORD_W / 8),
  localparam int WA_W      = ADDR_W - SHIFT,
  localparam int LIMIT     = CLK_KHZ * TIMEOUT_MS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 busy,
  output logic                 done,
  output logic [3*LANES-1:0]   err_code,
  output logic [WORD_W-1:0]    last_status,
  output logic                 vpp_en,
  output logic                 fl_req,
  output logic                 fl_we,
  output logic [WA_W-1:0]      fl_addr,
  output logic [WORD_W-1:0]    fl_wdata,
  input  logic                 fl_ack,
  input  logic [WORD_W-1:0]    fl_rdata
);

  fers_state_e       state;
  logic [WA_W-1:0]   word_addr;
  logic              bus_start, bus_we;
  logic [7:0]        bus_cmd;
  logic              xfer_done;
  logic [WORD_W-1:0] bus_rdata;
  logic              expired;
  logic              all_ready;
  logic [LANES-1:0]  lane_ready;
  logic [3*LANES-1:0] code_next;

  // Replicate a command byte into every lane
  function automatic logic [WORD_W-1:0] mirror(input logic [7:0] c);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*LANE_W +: LANE_W] = LANE_W'(c);
    return m;
  endfunction

  // Per-lane status decode
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fers_err_e lcode;
    fers_lane_decode #(.LANE_W(LANE_W)) u_dec (
      .status (bus_rdata[g*LANE_W +: LANE_W]),
      .ready  (lane_ready[g]),
      .code   (lcode)
    );
    assign code_next[3*g +: 3] = lcode;
  end

  assign all_ready = &lane_ready;

  fers_poll_timer #(.LIMIT(LIMIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (state == SQ_CONF && xfer_done),
    .run     (state == SQ_POLL),
    .expired (expired)
  );

  fers_bus_if #(.AW(WA_W), .DW(WORD_W)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .start     (bus_start),
    .we        (bus_we),
    .addr      (word_addr),
    .wdata     (mirror(bus_cmd)),
    .xfer_done (xfer_done),
    .rdata     (bus_rdata),
    .fl_req    (fl_req),
    .fl_we     (fl_we),
    .fl_addr   (fl_addr),
    .fl_wdata  (fl_wdata),
    .fl_ack    (fl_ack),
    .fl_rdata  (fl_rdata)
  );

  // Which access to launch next
  always_comb begin
    bus_start = 1'b0;
    bus_we    = 1'b1;
    bus_cmd   = 8'h00;
    unique case (state)
      SQ_PWR: begin
        bus_start = 1'b1;
        bus_cmd   = CMD_SETUP;
      end
      SQ_SETUP: if (xfer_done) begin
        bus_start = 1'b1;
        bus_cmd   = CMD_CONFIRM;
      end
      SQ_CONF: if (xfer_done) begin
        bus_start = 1'b1;
        bus_we    = 1'b0;
      end
      SQ_POLL: if (xfer_done) begin
        bus_start = 1'b1;
        if (all_ready || expired) bus_cmd = CMD_CLRST;
        else bus_we = 1'b0;
      end
      SQ_CLR: if (xfer_done) begin
        bus_start = 1'b1;
        bus_cmd   = CMD_READARR;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      word_addr   <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      vpp_en      <= 1'b0;
      err_code    <= '0;
      last_status <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        SQ_IDLE: if (req_valid) begin
          word_addr <= req_addr[ADDR_W-1:SHIFT];
          busy      <= 1'b1;
          vpp_en    <= 1'b1;
          err_code  <= '0;
          state     <= SQ_PWR;
        end
        SQ_PWR:   state <= SQ_SETUP;
        SQ_SETUP: if (xfer_done) state <= SQ_CONF;
        SQ_CONF:  if (xfer_done) state <= SQ_POLL;
        SQ_POLL: if (xfer_done && (all_ready || expired)) begin
          vpp_en      <= 1'b0;
          last_status <= bus_rdata;
          err_code    <= code_next;
          state       <= SQ_CLR;
        end
        SQ_CLR: if (xfer_done) state <= SQ_RST;
        SQ_RST: if (xfer_done) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  a_r3_vpp_on_read: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !fl_we) |-> vpp_en);

  a_r3_vpp_off_cleanup: assert property (@(posedge clk) disable iff (rst)
    (fl_req && fl_we && (fl_wdata[7:0] == CMD_CLRST || fl_wdata[7:0] == CMD_READARR)) |-> !vpp_en);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_start_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !fl_req);

endmodule

// File: tb/sim_fers_erase_seq.sv
`timescale 1ns/1ps
module sim_fers_erase_seq;

  localparam int LIMIT = 50 * 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [23:0] req_addr;
  logic        busy, done, vpp_en, fl_req, fl_we, fl_ack;
  logic [5:0]  err_code;
  logic [15:0] last_status, fl_wdata, fl_rdata;
  logic [22:0] fl_addr;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fers_erase_seq #(.CLK_KHZ(50), .TIMEOUT_MS(4)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .done(done), .err_code(err_code), .last_status(last_status),
    .vpp_en(vpp_en), .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_ack(fl_ack), .fl_rdata(fl_rdata)
  );

  // ---------------- flash model ----------------
  logic        clr_log = 1'b0;
  logic [22:0] exp_waddr = '0;
  int          rdy_after [2];
  logic [7:0]  fin_st [2];
  logic [15:0] wlog [8];
  int          nwr, nrd, lat;
  logic        addr_bad, vpp_bad;

  initial begin
    fl_ack = 1'b0; fl_rdata = '0; nwr = 0; nrd = 0; lat = 0;
    addr_bad = 1'b0; vpp_bad = 1'b0;
    rdy_after[0] = 1; rdy_after[1] = 1; fin_st[0] = 8'h80; fin_st[1] = 8'h80;
  end

  always @(posedge clk) begin
    fl_ack <= 1'b0;
    if (clr_log) begin
      nwr <= 0; nrd <= 0; lat <= 0; addr_bad <= 1'b0; vpp_bad <= 1'b0;
    end else if (fl_req && !fl_ack) begin
      if (lat == 1) begin
        fl_ack <= 1'b1;
        lat    <= 0;
        if (fl_addr !== exp_waddr) addr_bad <= 1'b1;
        if (fl_we) begin
          if (nwr < 8) wlog[nwr] <= fl_wdata;
          nwr <= nwr + 1;
          if (vpp_en !== (fl_wdata[7:0] == 8'h20 || fl_wdata[7:0] == 8'hD0)) vpp_bad <= 1'b1;
        end else begin
          nrd <= nrd + 1;
          if (!vpp_en) vpp_bad <= 1'b1;
          for (int l = 0; l < 2; l++)
            fl_rdata[l*8 +: 8] <= (nrd + 1 >= rdy_after[l]) ? fin_st[l] : 8'h00;
        end
      end else begin
        lat <= lat + 1;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] want_code(input logic [7:0] st);
    if (!st[7]) return 3'd4;
    if (st[1]) return 3'd1;
    if (st[3]) return 3'd2;
    if (st[4] | st[5]) return 3'd3;
    return 3'd0;
  endfunction

  task automatic setup_op(input logic [23:0] a, input int r0, input int r1,
                          input logic [7:0] s0, input logic [7:0] s1);
    exp_waddr = a[23:1];
    rdy_after[0] = r0; rdy_after[1] = r1;
    fin_st[0] = s0; fin_st[1] = s1;
    clr_log = 1'b1;
    @(negedge clk);
    clr_log = 1'b0;
  endtask

  task automatic pulse_req(input logic [23:0] a);
    req_addr  = a;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_seq(input string tag);
    chk({tag, " R4 write count"}, nwr, 4);
    chk({tag, " R4 setup"},   wlog[0], 16'h2020);
    chk({tag, " R4 confirm"}, wlog[1], 16'hD0D0);
    chk({tag, " R4 clear"},   wlog[2], 16'h5050);
    chk({tag, " R4 readmode"}, wlog[3], 16'hFFFF);
    chk({tag, " R2 address"}, addr_bad, 0);
    chk({tag, " R3 vpp per access"}, vpp_bad, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 vpp_en", vpp_en, 0);
    chk("R1 fl_req", fl_req, 0);
    chk("R1 err_code", err_code, 0);
    chk("R1 last_status", last_status, 0);
  endtask

  task automatic t_clean();
    int cyc;
    setup_op(24'h012340, 3, 3, 8'h80, 8'h80);
    pulse_req(24'h012340);
    chk("R3 vpp after accept", vpp_en, 1);
    wait_done(cyc);
    chk("R10 done seen", done, 1);
    chk("R10 busy low with done", busy, 0);
    chk("R7 clean codes", err_code, 0);
    chk("R8 last status", last_status, 16'h8080);
    chk("R5 reads until ready", nrd, 3);
    chk("R3 vpp low at end", vpp_en, 0);
    check_seq("clean");
    @(negedge clk);
    chk("R10 done one cycle", done, 0);
  endtask

  task automatic t_skew();
    int cyc;
    setup_op(24'h00F000, 1, 5, 8'h80, 8'h80);
    pulse_req(24'h00F000);
    wait_done(cyc);
    chk("R5 slow lane decides", nrd, 5);
    chk("R7 skew codes", err_code, 0);
    check_seq("skew");
    @(negedge clk);
  endtask

  task automatic t_decode(input logic [7:0] s0, input logic [7:0] s1);
    int cyc;
    setup_op(24'h200000, 2, 2, s0, s1);
    pulse_req(24'h200000);
    wait_done(cyc);
    chk("R7 lane0 code", err_code[2:0], want_code(s0));
    chk("R7 lane1 code", err_code[5:3], want_code(s1));
    chk("R8 status word", last_status, {s1, s0});
    check_seq("decode");
    @(negedge clk);
  endtask

  task automatic t_timeout();
    int cyc;
    setup_op(24'h3FFF00, 2, 100000, 8'h82, 8'h80);
    pulse_req(24'h3FFF00);
    wait_done(cyc);
    chk("R6 done reached", done, 1);
    chk("R6 waited long enough", (cyc > LIMIT) ? 1 : 0, 1);
    chk("R6 lane1 timeout code", err_code[5:3], 3'd4);
    chk("R7 lane0 ready code", err_code[2:0], 3'd1);
    chk("R8 status after timeout", last_status, 16'h0082);
    check_seq("timeout");
    @(negedge clk);
  endtask

  task automatic t_ignore();
    int cyc;
    setup_op(24'h004000, 6, 6, 8'h80, 8'h80);
    pulse_req(24'h004000);
    repeat (10) @(negedge clk);
    pulse_req(24'h0A0000);
    wait_done(cyc);
    check_seq("R9 ignore");
    repeat (20) @(negedge clk);
    chk("R9 no extra operation", busy, 0);
    chk("R9 no extra writes", nwr, 4);
  endtask

  task automatic t_backtoback();
    int cyc;
    setup_op(24'h006000, 2, 2, 8'h80, 8'h80);
    req_addr  = 24'h006000;
    req_valid = 1'b1;
    @(negedge clk);
    req_addr = 24'h00A000;
    wait_done(cyc);
    check_seq("R9 first op");
    exp_waddr = 24'h00A000 >> 1;
    clr_log   = 1'b1;
    @(negedge clk);
    clr_log   = 1'b0;
    req_valid = 1'b0;
    chk("R9 accepted in done cycle", busy, 1);
    wait_done(cyc);
    check_seq("R9 second op");
    repeat (10) @(negedge clk);
    chk("R10 only two operations", busy, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_skew();
    t_decode(8'h8A, 8'h98);
    t_decode(8'hA0, 8'h90);
    t_decode(8'h88, 8'h80);
    t_timeout();
    t_ignore();
    t_backtoback();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule